// File: doc/BRIEF.md
# APB Transfer Sequencer (Requester Side)

This block turns single transfer commands from a local requester into APB3 bus cycles toward one peripheral. A command carries an address, a write flag and write data. The sequencer moves through an idle phase, a one-cycle setup phase and an access phase. It drives the select, enable, address, direction and write-data lines. It stretches the access phase for as long as the peripheral holds its ready line low.

When a transfer completes, the block captures the peripheral's read data and error flag. In the next cycle it presents them on a one-cycle done pulse. A command may be accepted in the same cycle that the previous transfer completes. The next setup phase then follows at once, and select stays high between the two transfers.

The command port is valid/ready. The requester holds `cmd_valid` and the command fields steady until it sees `cmd_ready` high at a rising edge. `cmd_ready` is high in idle, and in access only during the cycle the peripheral signals ready. Back-pressure therefore lasts from acceptance until the completing cycle of the running transfer.

Top module: `apbm_seq`

## Requirements
- R1: After reset is released, `apb_sel`, `apb_en` and `rsp_done` are low and `cmd_ready` is high.
- R2: `cmd_ready` is high only in idle (`apb_sel` low) or in an access cycle where `apb_rdy` is high. A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. `apb_rdy` has no effect outside access.
- R3: The cycle after acceptance is a setup cycle (`apb_sel`=1, `apb_en`=0). It lasts exactly one cycle and is always followed by an access cycle (`apb_sel`=1, `apb_en`=1).
- R4: During setup and access, `apb_addr`, `apb_wr` and `apb_wdata` equal the accepted command's fields and do not change until the next acceptance.
- R5: While `apb_rdy` is low in access, the next cycle is again access, with address, direction and write data unchanged.
- R6: An access cycle with `apb_rdy` high and no command accepted is followed by idle (`apb_sel`=0, `apb_en`=0).
- R7: An access cycle with `apb_rdy` high in which a command is accepted is followed by setup. `apb_sel` stays high and `apb_en` drops.
- R8: `rsp_done` is high for exactly the one cycle after each completing access cycle. `rsp_rdata` then shows the `apb_rdata` value sampled in that completing cycle. A peripheral that returns no read data on writes gives 0.
- R9: `apb_err` is sampled only in the completing cycle. Error or data values driven during wait cycles never reach `rsp_err` or `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered by the requester |
| cmd_ready | output | 1 | Sequencer can take a command this cycle |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-cycle pulse: a transfer finished |
| rsp_rdata | output | DATA_W | Read data captured at completion |
| rsp_err | output | 1 | Error flag captured at completion |
| apb_sel | output | 1 | Peripheral select |
| apb_en | output | 1 | Access-phase enable |
| apb_addr | output | ADDR_W | Bus address |
| apb_wr | output | 1 | Bus direction, 1 = write |
| apb_wdata | output | DATA_W | Bus write data |
| apb_rdy | input | 1 | Peripheral ready; low inserts wait cycles |
| apb_rdata | input | DATA_W | Peripheral read data |
| apb_err | input | 1 | Peripheral error; tie low if unused |

## Verification
A corrupted phase register shows at the bus within one cycle. It appears as an enable without select, a setup lasting two cycles, or select dropping between chained transfers. A fault in the command holding registers shows as an address or write-data change during wait cycles, seen on the next edge. A fault in the response path shows one cycle after completion: a missing or doubled done pulse, or stale or wait-cycle read data and error values.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;
endpackage

// File: rtl/apbm_phase_fsm.sv
module apbm_phase_fsm
  import apbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bus_rdy,
  output logic req_ready,
  output logic accept,
  output logic complete,
  output logic bus_sel,
  output logic bus_en
);
  phase_e phase_q, phase_d;

  always_comb begin
    complete  = (phase_q == PH_ACCESS) && bus_rdy;
    req_ready = (phase_q == PH_IDLE) || complete;
    accept    = req_valid && req_ready;
    bus_sel   = (phase_q == PH_SETUP) || (phase_q == PH_ACCESS);
    bus_en    = (phase_q == PH_ACCESS);
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: if (complete) phase_d = accept ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R3: setup is a single cycle and always leads to access
  a_r3_setup_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_en) |=> (bus_sel && bus_en));

  // R5: a wait cycle keeps the access phase
  a_r5_wait_stays_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_rdy) |=> (bus_sel && bus_en));

  // R6: completion without a new command returns to idle
  a_r6_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rdy && !req_valid) |=> (!bus_sel && !bus_en));

  // R7: completion with a new command chains into setup with select held
  a_r7_chain_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rdy && req_valid) |=> (bus_sel && !bus_en));

  // enable never appears without select
  a_r3_en_implies_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> bus_sel);
endmodule

// File: rtl/apbm_cmd_hold.sv
module apbm_cmd_hold #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_wr,
  output logic [DATA_W-1:0] out_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_wr    <= 1'b0;
      out_wdata <= '0;
    end else if (load) begin
      out_addr  <= in_addr;
      out_wr    <= in_wr;
      out_wdata <= in_wdata;
    end
  end

  // R4: bus command fields change only on acceptance
  a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(out_addr) && $stable(out_wr) && $stable(out_wdata)));
endmodule

// File: rtl/apbm_resp_cap.sv
module apbm_resp_cap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      done <= complete;
      if (complete) begin
        rdata <= bus_rdata;
        err   <= bus_err;
      end
    end
  end

  // R8: a transfer takes at least two cycles, so done never repeats back to back
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: wait-cycle values never reach the response
  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> ($stable(rdata) && $stable(err)));
endmodule

// File: rtl/apbm_seq.sv
module apbm_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              apb_sel,
  output logic              apb_en,
  output logic [ADDR_W-1:0] apb_addr,
  output logic              apb_wr,
  output logic [DATA_W-1:0] apb_wdata,
  input  logic              apb_rdy,
  input  logic [DATA_W-1:0] apb_rdata,
  input  logic              apb_err
);
  logic take;
  logic finish;

  apbm_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cmd_valid),
    .bus_rdy   (apb_rdy),
    .req_ready (cmd_ready),
    .accept    (take),
    .complete  (finish),
    .bus_sel   (apb_sel),
    .bus_en    (apb_en)
  );

  apbm_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .in_addr   (cmd_addr),
    .in_wr     (cmd_wr),
    .in_wdata  (cmd_wdata),
    .out_addr  (apb_addr),
    .out_wr    (apb_wr),
    .out_wdata (apb_wdata)
  );

  apbm_resp_cap #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .complete  (finish),
    .bus_rdata (apb_rdata),
    .bus_err   (apb_err),
    .done      (rsp_done),
    .rdata     (rsp_rdata),
    .err       (rsp_err)
  );

  // R2: ready only in idle or in a completing access cycle
  a_r2_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!apb_sel || (apb_en && apb_rdy)));

  // R8: done follows exactly the completing access cycles
  a_r8_done_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (apb_en && apb_rdy) |=> rsp_done);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(apb_en && apb_rdy) |=> !rsp_done);
endmodule

// File: tb/apbm_seq_bench.sv
module apbm_seq_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int ERR_BIT = AW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_wr = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic rsp_err;
  logic apb_sel, apb_en, apb_wr;
  logic [AW-1:0] apb_addr;
  logic [DW-1:0] apb_wdata;
  logic apb_rdy = 1'b0;
  logic [DW-1:0] apb_rdata = '0;
  logic apb_err = 1'b0;

  always #2.5 clk = ~clk;

  apbm_seq #(.ADDR_W(AW), .DATA_W(DW)) u_apbm_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .apb_sel(apb_sel), .apb_en(apb_en), .apb_addr(apb_addr), .apb_wr(apb_wr),
    .apb_wdata(apb_wdata), .apb_rdy(apb_rdy), .apb_rdata(apb_rdata), .apb_err(apb_err)
  );

  int total = 0;
  int fails = 0;
  int forced_wait = 0;
  int wait_left = 0;
  int b2b_seen = 0;
  logic [DW-1:0] slave_mem [16];
  logic [DW-1:0] shadow [16];

  // in-flight expectation queues
  logic [AW-1:0] q_addr [256];
  logic          q_wr   [256];
  logic [DW-1:0] q_wd   [256];
  logic [DW-1:0] q_rd   [256];
  logic          q_err  [256];
  int push_i = 0, setup_i = 0, done_i = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [AW-1:0] a);
    return a[ERR_BIT];
  endfunction

  function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a, input logic w);
    return w ? '0 : shadow[a[5:2]];
  endfunction

  // peripheral model: wait cycles, garbage outside completion
  initial begin
    for (int i = 0; i < 16; i++) slave_mem[i] = 32'h1000 + i;
    forever begin
      @(negedge clk);
      if (apb_sel && !apb_en) begin
        wait_left = (forced_wait >= 0) ? forced_wait : int'($urandom % 4);
        apb_rdy = 1'($urandom); apb_rdata = $urandom; apb_err = 1'($urandom);
      end else if (apb_sel && apb_en) begin
        if (wait_left > 0) begin
          wait_left--;
          apb_rdy = 1'b0; apb_rdata = $urandom; apb_err = 1'($urandom);
        end else begin
          apb_rdy = 1'b1;
          apb_err = apb_addr[ERR_BIT];
          apb_rdata = apb_wr ? '0 : slave_mem[apb_addr[5:2]];
          if (apb_wr && !apb_addr[ERR_BIT]) slave_mem[apb_addr[5:2]] = apb_wdata;
        end
      end else begin
        apb_rdy = 1'($urandom); apb_rdata = $urandom; apb_err = 1'($urandom);
      end
    end
  end

  // bus and response monitor
  initial begin
    logic p_setup, p_wait, p_done;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wd;
    logic p_wr;
    p_setup = 0; p_wait = 0; p_done = 0; p_addr = '0; p_wd = '0; p_wr = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk); #2;
      if (p_setup) chk(apb_sel && apb_en, "R3", "access after setup", {apb_sel, apb_en}, 2'b11);
      if (p_wait) begin
        chk(apb_sel && apb_en, "R5", "still access", {apb_sel, apb_en}, 2'b11);
        chk(apb_addr == p_addr && apb_wr == p_wr && apb_wdata == p_wd, "R5", "fields held",
            apb_addr, p_addr);
      end
      if (p_done) begin
        if (apb_sel) begin
          chk(!apb_en, "R7", "chained setup enable", apb_en, 0);
          b2b_seen++;
        end else chk(!apb_en, "R6", "idle enable", apb_en, 0);
        chk(rsp_done, "R8", "done pulse", rsp_done, 1);
        chk(rsp_rdata == q_rd[done_i % 256], "R8", "read data", rsp_rdata, q_rd[done_i % 256]);
        chk(rsp_err == q_err[done_i % 256], "R9", "error flag", rsp_err, q_err[done_i % 256]);
        done_i++;
      end else chk(!rsp_done, "R8", "no stray done", rsp_done, 0);
      if (apb_sel && !apb_en) begin
        chk(!cmd_ready, "R2", "ready low in setup", cmd_ready, 0);
        chk(apb_addr == q_addr[setup_i % 256], "R4", "address", apb_addr, q_addr[setup_i % 256]);
        chk(apb_wr == q_wr[setup_i % 256], "R4", "direction", apb_wr, q_wr[setup_i % 256]);
        chk(apb_wdata == q_wd[setup_i % 256], "R4", "write data", apb_wdata, q_wd[setup_i % 256]);
        setup_i++;
      end
      if (apb_en && !apb_rdy) chk(!cmd_ready, "R2", "ready low in wait", cmd_ready, 0);
      if (!apb_sel) chk(cmd_ready, "R2", "ready in idle", cmd_ready, 1);
      p_setup = apb_sel && !apb_en;
      p_wait  = apb_en && !apb_rdy;
      p_done  = apb_en && apb_rdy;
      p_addr = apb_addr; p_wr = apb_wr; p_wd = apb_wdata;
    end
  end

  // called at negedge+1; leaves the bench at the next negedge+1 with valid low
  task automatic send(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    cmd_addr = a; cmd_wr = w; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    q_addr[push_i % 256] = a; q_wr[push_i % 256] = w; q_wd[push_i % 256] = d;
    q_rd[push_i % 256] = exp_rdata(a, w); q_err[push_i % 256] = exp_err(a);
    if (w && !exp_err(a)) shadow[a[5:2]] = d;
    push_i++;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) shadow[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(!apb_sel && !apb_en, "R1", "bus idle", {apb_sel, apb_en}, 0);
    chk(!rsp_done, "R1", "done low", rsp_done, 0);
    chk(cmd_ready, "R1", "ready high", cmd_ready, 1);
    // R2: stray peripheral ready in idle does nothing
    gap(5);
    chk(!apb_sel && !rsp_done, "R2", "idle undisturbed", {apb_sel, rsp_done}, 0);
    // no-wait single transfers
    forced_wait = 0;
    send(12'h014, 1'b1, 32'hCAFE_0001); gap(4);
    send(12'h014, 1'b0, '0); gap(4);
    // long waits, chained (R5, R7, R9)
    forced_wait = 3;
    send(12'h020, 1'b1, 32'hA5A5_0002);
    send(12'h020, 1'b0, '0);
    send(12'h820, 1'b1, 32'hDEAD_BEEF);
    send(12'h820, 1'b0, '0); gap(8);
    // zero-wait burst
    forced_wait = 0;
    for (int i = 0; i < 4; i++) send(AW'(i * 4), 1'b1, 32'h5000 + i);
    for (int i = 0; i < 4; i++) send(AW'(i * 4), 1'b0, '0);
    gap(4);
    chk(b2b_seen >= 8, "R7", "chained transfers seen", b2b_seen, 8);
    // random mix
    forced_wait = -1;
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      a = {($urandom % 8) == 0, 5'b0, 4'($urandom), 2'b00};
      send(a, 1'($urandom), $urandom);
      gap(int'($urandom % 3));
    end
    gap(10);
    chk(done_i == push_i, "R8", "all transfers answered", done_i, push_i);
    finish_run();
  end
endmodule